// File: doc/BRIEF.md
# Prevalidated Cache Tag Array

This block is the tag store of a 4-way set associative data cache. It keeps no physical address per line. Each line holds a one-hot vector that points at the TLB entry translating it, plus a valid bit. A lookup therefore needs no wide equality compare. The requesting port presents the TLB match vector it just obtained, and a way hits when its line is valid and the stored vector shares a set bit with that match vector. Two read ports work independently. Each port takes its own set index and match vector, and returns a hit flag, a one-hot way select and an error flag.

Three kinds of write change the array. A fill writes a TLB match vector into a chosen way of a set and marks the line valid. An invalidate clears one line, named by set and way. A TLB purge names the TLB entry being replaced, and in a single cycle it drops every line in every set whose vector has that entry's bit set.

Each port checks the vectors it reads. A valid line whose vector has more than one bit set counts as corrupt. It is reported and treated as a miss, which is safe because the cache is write-through. When two or more ways hit at once, the port reports an error and suppresses the hit.

Top module: `prevalid_tag_array`

## Requirements
- R1: While reset is held and after it is released, every line is invalid and every read output is 0 until a fill lands.
- R2: Read results are registered. The index and match vector present before a rising edge produce hit, select and error after that edge. Way w maps to select bit w. A way hits when its line is valid, its vector is not multi-hot, and the AND of its vector with the match vector is nonzero.
- R3: The two read ports are independent. Each port's result depends only on its own index and match vector.
- R4: A fill stores the fill vector in way `fillWay` of set `fillIdx` and marks the line valid. It is visible to reads from the next edge on. A read of that set in the same cycle returns the old contents.
- R5: An invalidate clears the valid bit of line (`invIdx`, `invWay`), and later reads of that line miss. Other lines are unchanged.
- R6: A purge of TLB entry e clears, in one cycle and across all sets and ways, every line whose vector has bit e set. Lines without bit e are unchanged.
- R7: A valid line whose stored vector has two or more bits set raises the error flag on a read of its set. That way never hits.
- R8: When two or more ways hit, the port outputs hit 0, select 0 and error 1. Otherwise hit is 1 exactly when the select is nonzero.
- R9: An invalidate or purge in the same cycle as a fill to the same line takes precedence. The line ends invalid, and the purge is tested against the newly written vector.
- R10: An invalid line never hits and never raises the error flag, whatever its stored vector.
- R11: An all-zero match vector never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdIdx0 | input | 6 | Port 0 set index |
| rdMatch0 | input | 32 | Port 0 TLB match vector |
| rdHit0 | output | 1 | Port 0 hit |
| rdWaySel0 | output | 4 | Port 0 one-hot way select, bit w = way w |
| rdErr0 | output | 1 | Port 0 multi-hot vector or multi-way hit |
| rdIdx1 | input | 6 | Port 1 set index |
| rdMatch1 | input | 32 | Port 1 TLB match vector |
| rdHit1 | output | 1 | Port 1 hit |
| rdWaySel1 | output | 4 | Port 1 one-hot way select |
| rdErr1 | output | 1 | Port 1 error |
| fillEn | input | 1 | Fill strobe |
| fillIdx | input | 6 | Fill set |
| fillWay | input | 2 | Fill way |
| fillVec | input | 32 | Vector to store |
| invEn | input | 1 | Single-line invalidate strobe |
| invIdx | input | 6 | Invalidate set |
| invWay | input | 2 | Invalidate way |
| purgeEn | input | 1 | TLB entry replacement strobe |
| purgeEntry | input | 5 | TLB entry being replaced |

## Verification
Every read result is due one rising edge after its index and match vector were driven. Writes take effect at the same edge, so they show up in reads driven for the following edge. The bench drives inputs at the falling edge. At the rising edge it computes the expected read from its model as it stood before that edge's writes, then applies the writes to the model, and it compares the outputs at the next falling edge. This makes the old-contents case for a read and write in the same cycle fall out of the same cycle-by-cycle comparison that covers every other result.

// File: rtl/ptag_pkg.sv
package ptag_pkg;
  localparam int NUM_SETS    = 64;
  localparam int NUM_WAYS    = 4;
  localparam int TLB_ENTRIES = 32;
  localparam int NUM_PORTS   = 2;
  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int ENT_W = $clog2(TLB_ENTRIES);

  typedef logic [IDX_W-1:0]       idx_t;
  typedef logic [WAY_W-1:0]       way_t;
  typedef logic [TLB_ENTRIES-1:0] vec_t;
  typedef logic [NUM_WAYS-1:0]    wayMask_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     fillEn;
    idx_t     fillIdx;
    way_t     fillWay;
    wayMask_t fillWayOH;
    vec_t     fillVec;
    logic     invEn;
    idx_t     invIdx;
    way_t     invWay;
    wayMask_t invWayOH;
    vec_t     purgeMask;
  } tagStrobes_t;
endpackage

// File: rtl/ptag_ctrl.sv
module ptag_ctrl
  import ptag_pkg::*;
(
  input  logic        fillEn,
  input  idx_t        fillIdx,
  input  way_t        fillWay,
  input  vec_t        fillVec,
  input  logic        invEn,
  input  idx_t        invIdx,
  input  way_t        invWay,
  input  logic        purgeEn,
  input  logic [ENT_W-1:0] purgeEntry,
  output tagStrobes_t strb
);
  always_comb begin
    strb.fillEn    = fillEn;
    strb.fillIdx   = fillIdx;
    strb.fillWay   = fillWay;
    strb.fillWayOH = fillEn ? (wayMask_t'(1) << fillWay) : '0;
    strb.fillVec   = fillVec;
    strb.invEn     = invEn;
    strb.invIdx    = invIdx;
    strb.invWay    = invWay;
    strb.invWayOH  = invEn ? (wayMask_t'(1) << invWay) : '0;
    strb.purgeMask = purgeEn ? (vec_t'(1) << purgeEntry) : '0;
  end
endmodule

// File: rtl/ptag_datapath.sv
module ptag_datapath
  import ptag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  tagStrobes_t strb,
  input  idx_t        rdIdx   [NUM_PORTS],
  input  vec_t        rdMatch [NUM_PORTS],
  output logic        rdHit   [NUM_PORTS],
  output wayMask_t    rdWaySel[NUM_PORTS],
  output logic        rdErr   [NUM_PORTS]
);
  vec_t vecQ   [NUM_SETS][NUM_WAYS];
  logic validQ [NUM_SETS][NUM_WAYS];

  // storage: fill, then invalidate, then purge against the new vector
  for (genvar s = 0; s < NUM_SETS; s++) begin : gSet
    for (genvar w = 0; w < NUM_WAYS; w++) begin : gWay
      logic fillHere, invHere, validN;
      vec_t vecN;
      always_comb begin
        fillHere = strb.fillEn && (strb.fillIdx == idx_t'(s)) && strb.fillWayOH[w];
        invHere  = strb.invEn && (strb.invIdx == idx_t'(s)) && strb.invWayOH[w];
        vecN     = fillHere ? strb.fillVec : vecQ[s][w];
        validN   = (fillHere || validQ[s][w]) && !invHere && ((vecN & strb.purgeMask) == '0);
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          vecQ[s][w]   <= '0;
          validQ[s][w] <= 1'b0;
        end else begin
          vecQ[s][w]   <= vecN;
          validQ[s][w] <= validN;
        end
      end
    end
  end

  // read ports
  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    wayMask_t wayHit, wayBad;
    logic multiHit;
    always_comb begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        wayBad[w] = validQ[rdIdx[p]][w] &&
                    ((vecQ[rdIdx[p]][w] & (vecQ[rdIdx[p]][w] - vec_t'(1))) != '0);
        wayHit[w] = validQ[rdIdx[p]][w] && !wayBad[w] &&
                    ((vecQ[rdIdx[p]][w] & rdMatch[p]) != '0);
      end
      multiHit = (wayHit & (wayHit - wayMask_t'(1))) != '0;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdHit[p]    <= 1'b0;
        rdWaySel[p] <= '0;
        rdErr[p]    <= 1'b0;
      end else begin
        rdHit[p]    <= (wayHit != '0) && !multiHit;
        rdWaySel[p] <= multiHit ? '0 : wayHit;
        rdErr[p]    <= (wayBad != '0) || multiHit;
      end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(rdWaySel[p])); // R2
    AST_HIT_SEL_AGREE: assert property (@(posedge clk) disable iff (!rstN)
      rdHit[p] == (rdWaySel[p] != '0)); // R8
    AST_ZERO_MATCH_MISS: assert property (@(posedge clk) disable iff (!rstN)
      (rdMatch[p] == '0) |=> !rdHit[p]); // R11
  end

  // assertion support: purge mask of the previous cycle
  vec_t lastPurge;
  logic purgeLeft;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastPurge <= '0;
    else       lastPurge <= strb.purgeMask;
  end
  always_comb begin
    purgeLeft = 1'b0;
    for (int s = 0; s < NUM_SETS; s++)
      for (int w = 0; w < NUM_WAYS; w++)
        if (validQ[s][w] && ((vecQ[s][w] & lastPurge) != '0)) purgeLeft = 1'b1;
  end

  AST_PURGE_SWEPT: assert property (@(posedge clk) disable iff (!rstN)
    (lastPurge != '0) |-> !purgeLeft); // R6
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.invEn |=> !validQ[$past(strb.invIdx)][$past(strb.invWay)]); // R5
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillEn && ((strb.fillVec & strb.purgeMask) == '0) &&
     !(strb.invEn && strb.invIdx == strb.fillIdx && strb.invWay == strb.fillWay))
    |=> validQ[$past(strb.fillIdx)][$past(strb.fillWay)]); // R4
endmodule

// File: rtl/prevalid_tag_array.sv
module prevalid_tag_array
  import ptag_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [IDX_W-1:0]       rdIdx0,
  input  logic [TLB_ENTRIES-1:0] rdMatch0,
  output logic                   rdHit0,
  output logic [NUM_WAYS-1:0]    rdWaySel0,
  output logic                   rdErr0,
  input  logic [IDX_W-1:0]       rdIdx1,
  input  logic [TLB_ENTRIES-1:0] rdMatch1,
  output logic                   rdHit1,
  output logic [NUM_WAYS-1:0]    rdWaySel1,
  output logic                   rdErr1,
  input  logic                   fillEn,
  input  logic [IDX_W-1:0]       fillIdx,
  input  logic [WAY_W-1:0]       fillWay,
  input  logic [TLB_ENTRIES-1:0] fillVec,
  input  logic                   invEn,
  input  logic [IDX_W-1:0]       invIdx,
  input  logic [WAY_W-1:0]       invWay,
  input  logic                   purgeEn,
  input  logic [ENT_W-1:0]       purgeEntry
);
  tagStrobes_t strb;
  idx_t        rdIdx   [NUM_PORTS];
  vec_t        rdMatch [NUM_PORTS];
  logic        rdHit   [NUM_PORTS];
  wayMask_t    rdWaySel[NUM_PORTS];
  logic        rdErr   [NUM_PORTS];

  assign rdIdx[0]   = rdIdx0;
  assign rdIdx[1]   = rdIdx1;
  assign rdMatch[0] = rdMatch0;
  assign rdMatch[1] = rdMatch1;
  assign rdHit0     = rdHit[0];
  assign rdHit1     = rdHit[1];
  assign rdWaySel0  = rdWaySel[0];
  assign rdWaySel1  = rdWaySel[1];
  assign rdErr0     = rdErr[0];
  assign rdErr1     = rdErr[1];

  ptag_ctrl u_ctrl (
    .fillEn(fillEn), .fillIdx(fillIdx), .fillWay(fillWay), .fillVec(fillVec),
    .invEn(invEn), .invIdx(invIdx), .invWay(invWay),
    .purgeEn(purgeEn), .purgeEntry(purgeEntry), .strb(strb)
  );

  ptag_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdIdx(rdIdx), .rdMatch(rdMatch),
    .rdHit(rdHit), .rdWaySel(rdWaySel), .rdErr(rdErr)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!rdHit0 && !rdHit1 && !rdErr0 && !rdErr1)); // R1
endmodule

// File: tb/prevalid_tag_array_bench.sv
module prevalid_tag_array_bench;
  logic clk = 0, rstN = 0;
  logic [5:0] rdIdx0 = 0, rdIdx1 = 0, fillIdx = 0, invIdx = 0;
  logic [31:0] rdMatch0 = 0, rdMatch1 = 0, fillVec = 0;
  logic [1:0] fillWay = 0, invWay = 0;
  logic [4:0] purgeEntry = 0;
  logic fillEn = 0, invEn = 0, purgeEn = 0;
  logic rdHit0, rdHit1, rdErr0, rdErr1;
  logic [3:0] rdWaySel0, rdWaySel1;

  prevalid_tag_array u_prevalid_tag_array (.*);

  always #10 clk = ~clk;

  bit [31:0] mVec [64][4];
  bit        mValid [64][4];
  int nTests = 0, nFail = 0;
  bit done = 0;
  string tag = "R1";
  bit eHit [2]; bit [3:0] eSel [2]; bit eErr [2];

  task automatic expect_read(input int p, input int idx, input bit [31:0] m);
    bit [3:0] hits = 0; bit err = 0;
    for (int w = 0; w < 4; w++)
      if (mValid[idx][w]) begin
        if ($countones(mVec[idx][w]) > 1) err = 1;
        else if ((mVec[idx][w] & m) != 0) hits[w] = 1;
      end
    if ($countones(hits) > 1) begin eHit[p] = 0; eSel[p] = 0; eErr[p] = 1; end
    else begin eHit[p] = (hits != 0); eSel[p] = hits; eErr[p] = err; end
  endtask

  task automatic check(input string req, input int p, input bit h, input bit [3:0] s, input bit e,
                       input bit xh, input bit [3:0] xs, input bit xe);
    nTests++;
    if (h !== xh || s !== xs || e !== xe) begin
      nFail++;
      $display("FAIL %s port%0d: hit=%0b sel=%b err=%0b expected hit=%0b sel=%b err=%0b",
               req, p, h, s, e, xh, xs, xe);
    end
  endtask

  // one clock: expected from pre-edge model, then model update, then compare
  task automatic step();
    @(posedge clk);
    expect_read(0, rdIdx0, rdMatch0);
    expect_read(1, rdIdx1, rdMatch1);
    if (fillEn) begin mVec[fillIdx][fillWay] = fillVec; mValid[fillIdx][fillWay] = 1; end
    if (invEn) mValid[invIdx][invWay] = 0;
    if (purgeEn)
      for (int s = 0; s < 64; s++)
        for (int w = 0; w < 4; w++)
          if (mVec[s][w][purgeEntry]) mValid[s][w] = 0;
    @(negedge clk);
    check(tag, 0, rdHit0, rdWaySel0, rdErr0, eHit[0], eSel[0], eErr[0]);
    check(tag, 1, rdHit1, rdWaySel1, rdErr1, eHit[1], eSel[1], eErr[1]);
    fillEn = 0; invEn = 0; purgeEn = 0;
  endtask

  task automatic fill(input int idx, input int way, input bit [31:0] v);
    fillEn = 1; fillIdx = idx; fillWay = way; fillVec = v;
  endtask
  task automatic rd(input int p, input int idx, input bit [31:0] m);
    if (p == 0) begin rdIdx0 = idx; rdMatch0 = m; end
    else begin rdIdx1 = idx; rdMatch1 = m; end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1", 0, rdHit0, rdWaySel0, rdErr0, 0, 0, 0);
    rstN = 1;
    @(negedge clk);
    tag = "R1"; rd(0, 0, '1); rd(1, 63, '1); step();

    // R4: same-cycle read returns old contents, next read sees fill
    tag = "R4"; fill(5, 2, 32'h80); rd(0, 5, 32'h80); step();
    step();
    check("R2", 0, rdHit0, rdWaySel0, rdErr0, 1, 4'b0100, 0);

    // R3: independent ports
    tag = "R3"; fill(9, 0, 32'h1); step();
    rd(0, 5, 32'h80); rd(1, 9, 32'h1); step();
    check("R3", 1, rdHit1, rdWaySel1, rdErr1, 1, 4'b0001, 0);
    rd(1, 5, 32'h1); step();

    // R11: zero match vector
    tag = "R11"; rd(0, 5, 32'h0); step();

    // R5: invalidate one line
    tag = "R5"; invEn = 1; invIdx = 5; invWay = 2; rd(0, 5, 32'h80); rd(1, 9, 32'h1); step();
    step();

    // R6: purge across sets
    tag = "R6"; fill(10, 1, 32'h8); step(); fill(40, 3, 32'h8); step();
    fill(40, 0, 32'h10); step();
    purgeEn = 1; purgeEntry = 3; rd(0, 40, 32'h18); rd(1, 10, 32'h8); step();
    step();
    check("R6", 0, rdHit0, rdWaySel0, rdErr0, 1, 4'b0001, 0);

    // R7: multi-hot stored vector
    tag = "R7"; fill(20, 1, 32'h6); step(); fill(20, 2, 32'h100); step();
    rd(0, 20, 32'h106); step();
    check("R7", 0, rdHit0, rdWaySel0, rdErr0, 1, 4'b0100, 1);

    // R10: invalid line with corrupt vector stays silent
    tag = "R10"; invEn = 1; invIdx = 20; invWay = 1; step();
    rd(0, 20, 32'h6); step();
    check("R10", 0, rdHit0, rdWaySel0, rdErr0, 0, 0, 0);

    // R8: two ways hit
    tag = "R8"; fill(30, 0, 32'h400); step(); fill(30, 3, 32'h400); step();
    rd(0, 30, 32'h400); step();
    check("R8", 0, rdHit0, rdWaySel0, rdErr0, 0, 0, 1);

    // R9: conflicts with a fill
    tag = "R9"; fill(50, 1, 32'h20); invEn = 1; invIdx = 50; invWay = 1; step();
    rd(0, 50, 32'h20); step();
    fill(51, 2, 32'h40); purgeEn = 1; purgeEntry = 6; step();
    rd(0, 51, 32'h40); step();
    check("R9", 0, rdHit0, rdWaySel0, rdErr0, 0, 0, 0);

    // R2: random traffic compared every cycle
    tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 40) begin
        bit [31:0] v = 32'h1 << ($urandom % 8);
        if ($urandom % 10 == 0) v |= 32'h1 << ($urandom % 8);
        fill(($urandom % 5 == 4) ? 63 : $urandom % 4, $urandom % 4, v);
      end
      if ($urandom % 100 < 15) begin
        invEn = 1; invIdx = ($urandom % 5 == 4) ? 63 : $urandom % 4; invWay = $urandom % 4;
      end
      if ($urandom % 100 < 8) begin purgeEn = 1; purgeEntry = $urandom % 8; end
      for (int p = 0; p < 2; p++) begin
        bit [31:0] m = ($urandom % 8 == 0) ? 32'h0 : (32'h1 << ($urandom % 8));
        if ($urandom % 4 == 0) m |= 32'h1 << ($urandom % 8);
        rd(p, ($urandom % 5 == 4) ? 63 : $urandom % 4, m);
      end
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule